// File: doc/BRIEF.md
# CAN Bit Timing and Sampler

This block divides the system clock into time quanta and walks every nominal bit time through four segments: a fixed one-quantum sync segment, a programmable propagation segment, and two programmable phase buffers. At the boundary between the first and second phase buffers it decides the received bit. It can use the line level at that instant or a 2-of-3 majority over that instant and the two preceding quantum boundaries. It raises a one-cycle strobe with each decided bit and another at the start of every bit. The transmit data bit is latched on that start-of-bit strobe.

While the bus is idle, a falling (recessive-to-dominant) edge on the receive line hard-resynchronizes the timer. The prescaler and segment sequencer restart at the beginning of the sync segment. A listen-only input holds the transmit output recessive, and reception goes on as usual. The receive line is taken as already synchronized to the clock. The configuration inputs are expected to be stable while the block is out of reset.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts `presc_div + 1` clock cycles. A `presc_div` of zero gives one quantum on every clock cycle.
- R2: A bit lasts `1 + (prop_len+1) + (ph1_len+1) + (ph2_len+1)` quanta. The sync segment is always one quantum. Consecutive `tx_stb` pulses are therefore that many quanta apart when no resynchronization occurs.
- R3: The sample point is the end of the last quantum of phase buffer 1. That is `(prop_len + ph1_len + 3)` quanta after the start of the bit, and `sample_stb` rises one cycle after that clock edge.
- R4: `sample_stb` is a one-cycle pulse. `rx_bit` changes only in the cycle where `sample_stb` is high, and it holds the decided value from then on.
- R5: `tx_stb` is a one-cycle pulse at the start of every bit. In that same cycle `tx_line` takes the value `tx_bit` had at the clock edge that started the bit, unless R9 applies.
- R6: With `triple_mode` = 0, the decided bit equals `rx_line` at the clock edge of the sample point.
- R7: With `triple_mode` = 1, the decided bit is the 2-of-3 majority of `rx_line` at three quantum-ending clock edges: the sample point and the two before it.
- R8: When `bus_idle` = 1 and `rx_line` was 1 at the previous edge and is 0 now, the bit timer restarts at the sync segment with a fresh prescaler count and `tx_stb` is raised. A sample point in that same cycle is dropped, so no `sample_stb` occurs.
- R9: With `listen_only` = 1, `tx_line` is 1 (recessive) in the same cycle. Sampling and strobes are unaffected.
- R10: With `bus_idle` = 0, falling edges on `rx_line` do not change bit timing.
- R11: During and right after reset, `sample_stb` = 0, `tx_stb` = 0, `rx_bit` = 1 and `tx_line` = 1. The first bit starts at the sync segment on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_div | input | 8 | Prescaler setting; quantum = setting + 1 clocks |
| prop_len | input | 3 | Propagation segment length minus one, in quanta |
| ph1_len | input | 3 | Phase buffer 1 length minus one, in quanta |
| ph2_len | input | 3 | Phase buffer 2 length minus one, in quanta |
| triple_mode | input | 1 | 1 = three-sample majority, 0 = single sample |
| listen_only | input | 1 | 1 = hold transmit output recessive |
| bus_idle | input | 1 | 1 = bus idle, hard resynchronization allowed |
| rx_line | input | 1 | Synchronized receive line (1 = recessive) |
| tx_bit | input | 1 | Bit to transmit, latched at bit start |
| rx_bit | output | 1 | Last decided received bit |
| sample_stb | output | 1 | One-cycle strobe with each decided bit |
| tx_stb | output | 1 | One-cycle strobe at the start of each bit |
| tx_line | output | 1 | Transmit line (1 = recessive) |

## Verification
A hard-resynchronizing falling edge can arrive in the very clock cycle where the sample point (or the end of phase buffer 2) falls due. The restart must then win: the bit start is signalled, the sample is dropped, and the quantum history still shifts. The bench provokes this by holding `bus_idle` high while toggling `rx_line` at random run lengths, over several prescaler and segment settings, so that edges land on every position in the bit. A behavioural position counter in the bench predicts each strobe and the decided bit, and every output is compared on every clock.

// File: rtl/can_bt_pkg.sv
// Package: shared types and helpers for the CAN bit timer.
// Assumes: segment order SYNC -> PROP -> PH1 -> PH2 -> SYNC.
package can_bt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

    // Number of earlier quantum-boundary samples kept for the majority vote
    localparam int unsigned VOTE_HIST = 2;

    // Segment that follows the given one within a bit
    function automatic seg_e seg_after(input seg_e s);
        case (s)
            SEG_SYNC: seg_after = SEG_PROP;
            SEG_PROP: seg_after = SEG_PH1;
            SEG_PH1:  seg_after = SEG_PH2;
            default:  seg_after = SEG_SYNC;
        endcase
    endfunction

    // 2-of-3 majority
    function automatic logic vote3(input logic a, input logic b, input logic c);
        vote3 = (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/can_tq_prescaler.sv
// Module: time-quantum prescaler.
// Emits tq_en for one cycle every (div + 1) clocks. A restart clears the count,
// so the next quantum begins on the following clock.
// Assumes: div is stable outside of reset.
module can_tq_prescaler #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tq_en
);

    logic [DIV_W-1:0] cnt;

    // Quantum ends when the count reaches the programmed setting
    always_comb tq_en = (cnt == div);

    // Count clocks within the current quantum
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || tq_en)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/can_bit_sequencer.sv
// Module: bit segment sequencer.
// Steps through SYNC (1 quantum), PROP, PH1 and PH2 (each len + 1 quanta) on
// each tq_en. It flags the sample point (last quantum of PH1 ending) and the
// bit end (last quantum of PH2 ending). A restart forces SYNC, quantum 0, and
// suppresses both flags in that cycle.
// Assumes: lengths are stable outside of reset.
module can_bit_sequencer
    import can_bt_pkg::*;
#(
    parameter int unsigned SEG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_en,
    input  logic             restart,
    input  logic [SEG_W-1:0] prop_len,
    input  logic [SEG_W-1:0] ph1_len,
    input  logic [SEG_W-1:0] ph2_len,
    output logic             sample_pt,
    output logic             bit_end
);

    seg_e             seg;
    logic [SEG_W-1:0] qcnt;
    logic [SEG_W-1:0] cur_len;
    logic             seg_last;

    // Length (minus one) of the segment in progress
    always_comb begin
        case (seg)
            SEG_SYNC: cur_len = '0;
            SEG_PROP: cur_len = prop_len;
            SEG_PH1:  cur_len = ph1_len;
            default:  cur_len = ph2_len;
        endcase
    end

    // Segment boundary and event flags for this quantum edge
    always_comb begin
        seg_last  = (qcnt == cur_len);
        sample_pt = tq_en && !restart && seg_last && (seg == SEG_PH1);
        bit_end   = tq_en && !restart && seg_last && (seg == SEG_PH2);
    end

    // Advance quantum counter and segment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg  <= SEG_SYNC;
            qcnt <= '0;
        end else if (restart) begin
            seg  <= SEG_SYNC;
            qcnt <= '0;
        end else if (tq_en) begin
            if (seg_last) begin
                seg  <= seg_after(seg);
                qcnt <= '0;
            end else begin
                qcnt <= qcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/can_line_sampler.sv
// Module: receive line sampler.
// Keeps the line level seen at the previous VOTE_HIST quantum edges. At the
// sample point it decides the bit from the current level alone, or from a 2-of-3
// vote with the two stored levels, and raises sample_stb for one cycle.
// Assumes: rx_line is already synchronized to clk.
module can_line_sampler
    import can_bt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tq_en,
    input  logic sample_pt,
    input  logic triple_mode,
    input  logic rx_line,
    output logic rx_bit,
    output logic sample_stb
);

    logic [VOTE_HIST-1:0] hist;
    logic                 decided;

    // Bit decision: single level or majority with the two prior quantum edges
    always_comb decided = triple_mode ? vote3(rx_line, hist[0], hist[VOTE_HIST-1]) : rx_line;

    // Shift line history on each quantum edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '1;
        else if (tq_en)
            hist <= {hist[VOTE_HIST-2:0], rx_line};
    end

    // Register decided bit and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_bit     <= 1'b1;
            sample_stb <= 1'b0;
        end else begin
            sample_stb <= sample_pt;
            if (sample_pt)
                rx_bit <= decided;
        end
    end

endmodule

// File: rtl/can_bit_timer.sv
// Module: CAN bit timing and sampler (top).
// Combines the prescaler, segment sequencer and line sampler. Performs hard
// resynchronization on an idle-bus falling edge, produces the start-of-bit
// strobe, latches the transmit bit and applies listen-only masking.
// Assumes: configuration inputs are stable outside of reset; rx_line is synchronous.
module can_bit_timer #(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned SEG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] presc_div,
    input  logic [SEG_W-1:0] prop_len,
    input  logic [SEG_W-1:0] ph1_len,
    input  logic [SEG_W-1:0] ph2_len,
    input  logic             triple_mode,
    input  logic             listen_only,
    input  logic             bus_idle,
    input  logic             rx_line,
    input  logic             tx_bit,
    output logic             rx_bit,
    output logic             sample_stb,
    output logic             tx_stb,
    output logic             tx_line
);

    logic rx_prev;
    logic hard_sync;
    logic tq_en;
    logic sample_pt;
    logic bit_end;
    logic tx_q;

    // Remember the line level of the previous clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_prev <= 1'b1;
        else
            rx_prev <= rx_line;
    end

    // Idle-bus recessive-to-dominant edge restarts the bit
    always_comb hard_sync = bus_idle && rx_prev && !rx_line;

    can_tq_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (presc_div),
        .restart (hard_sync),
        .tq_en   (tq_en)
    );

    can_bit_sequencer #(.SEG_W(SEG_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tq_en     (tq_en),
        .restart   (hard_sync),
        .prop_len  (prop_len),
        .ph1_len   (ph1_len),
        .ph2_len   (ph2_len),
        .sample_pt (sample_pt),
        .bit_end   (bit_end)
    );

    can_line_sampler u_samp (
        .clk         (clk),
        .rst_n       (rst_n),
        .tq_en       (tq_en),
        .sample_pt   (sample_pt),
        .triple_mode (triple_mode),
        .rx_line     (rx_line),
        .rx_bit      (rx_bit),
        .sample_stb  (sample_stb)
    );

    // Start-of-bit strobe and transmit bit latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_stb <= 1'b0;
            tx_q   <= 1'b1;
        end else begin
            tx_stb <= hard_sync || bit_end;
            if (hard_sync || bit_end)
                tx_q <= tx_bit;
        end
    end

    // Listen-only keeps the line recessive
    always_comb tx_line = tx_q | listen_only;

endmodule

// File: rtl/can_bit_timer_chk.sv
// Module: assertion checker for can_bit_timer, attached by bind.
// Observes ports only.
module can_bit_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic listen_only,
    input logic bus_idle,
    input logic rx_line,
    input logic rx_bit,
    input logic sample_stb,
    input logic tx_stb,
    input logic tx_line
);

    // R4
    rx_bit_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_bit) |-> sample_stb);

    // R4
    sample_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    // R8
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_stb, tx_stb}));

    // R8
    hard_sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle && $past(rx_line) && !rx_line) |=> tx_stb);

    // R9
    listen_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        listen_only |-> tx_line);

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_stb && $stable(listen_only)) |-> $stable(tx_line));

endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .listen_only (listen_only),
    .bus_idle    (bus_idle),
    .rx_line     (rx_line),
    .rx_bit      (rx_bit),
    .sample_stb  (sample_stb),
    .tx_stb      (tx_stb),
    .tx_line     (tx_line)
);

// File: tb/test_can_bit_timer.sv
// Bench: behavioural position-counter model of the bit timer, compared on every clock.
module test_can_bit_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] presc_div = '0;
    logic [2:0] prop_len = '0, ph1_len = '0, ph2_len = '0;
    logic       triple_mode = 1'b0, listen_only = 1'b0, bus_idle = 1'b0;
    logic       rx_line = 1'b1, tx_bit = 1'b1;
    logic       rx_bit, sample_stb, tx_stb, tx_line;

    always #4 clk = ~clk;  // 125 MHz

    can_bit_timer i_can_bit_timer (
        .clk(clk), .rst_n(rst_n), .presc_div(presc_div), .prop_len(prop_len),
        .ph1_len(ph1_len), .ph2_len(ph2_len), .triple_mode(triple_mode),
        .listen_only(listen_only), .bus_idle(bus_idle), .rx_line(rx_line),
        .tx_bit(tx_bit), .rx_bit(rx_bit), .sample_stb(sample_stb),
        .tx_stb(tx_stb), .tx_line(tx_line)
    );

    int    n_cmp = 0, n_bad = 0;
    bit    done = 1'b0;
    string phase_tag = "R11";

    // reference model state
    int unsigned pos;
    bit prev_rx, txq, e_samp, e_tx, e_rx;
    bit hq[$];

    task automatic check1(string nm, string rq, logic act, bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s (phase %s) at %0t: actual %b expected %b",
                     rq, nm, phase_tag, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        pos = 0; prev_rx = 1'b1; txq = 1'b1;
        e_samp = 1'b0; e_tx = 1'b0; e_rx = 1'b1;
        hq = '{1'b1, 1'b1};
    endtask

    // One model step for the coming clock edge, from the inputs now applied
    task automatic model_step();
        int unsigned q, nq, cnt;
        bit hs, samp_ev, end_ev, dec;
        q   = presc_div + 1;
        nq  = 4 + prop_len + ph1_len + ph2_len;
        hs  = bus_idle && prev_rx && !rx_line;
        samp_ev = !hs && (pos == q * (prop_len + ph1_len + 3) - 1);
        end_ev  = !hs && (pos == q * nq - 1);
        if (triple_mode) begin
            cnt = int'(rx_line) + int'(hq[$]) + int'(hq[$-1]);
            dec = (cnt >= 2);
        end else begin
            dec = rx_line;
        end
        e_samp = samp_ev;
        if (samp_ev) e_rx = dec;
        e_tx = hs || end_ev;
        if (hs || end_ev) txq = tx_bit;
        if ((pos % q) == q - 1) begin
            hq.push_back(rx_line);
            void'(hq.pop_front());
        end
        pos = (hs || end_ev) ? 0 : pos + 1;
        prev_rx = rx_line;
    endtask

    // Compare at the falling edge, then drive new inputs and advance the model
    task automatic step(int chg_pct, bit idle, bit lo_rand);
        @(negedge clk);
        check1("sample_stb", "R3 R4", sample_stb, e_samp);
        check1("tx_stb", "R1 R2 R5", tx_stb, e_tx);
        check1("rx_bit", triple_mode ? "R7" : "R6", rx_bit, e_rx);
        check1("tx_line", "R5 R9", tx_line, txq | listen_only);
        if ($urandom_range(0, 99) < chg_pct) rx_line = ~rx_line;
        tx_bit   = $urandom_range(0, 1);
        bus_idle = idle;
        if (lo_rand && $urandom_range(0, 49) == 0) listen_only = ~listen_only;
        model_step();
    endtask

    task automatic do_reset(int d, int p, int a, int b, bit tri_m);
        rst_n = 1'b0; rx_line = 1'b1; bus_idle = 1'b0; listen_only = 1'b0;
        presc_div = d[7:0]; prop_len = p[2:0]; ph1_len = a[2:0]; ph2_len = b[2:0];
        triple_mode = tri_m;
        repeat (3) @(negedge clk);
        // R11 reset state
        check1("sample_stb", "R11", sample_stb, 1'b0);
        check1("tx_stb", "R11", tx_stb, 1'b0);
        check1("rx_bit", "R11", rx_bit, 1'b1);
        check1("tx_line", "R11", tx_line, 1'b1);
        rst_n = 1'b1;
        model_reset();
        model_step();
    endtask

    task automatic run(string tag, int n, int chg, bit idle, bit lo_rand);
        phase_tag = tag;
        for (int i = 0; i < n; i++) step(chg, idle, lo_rand);
    endtask

    initial begin
        do_reset(0, 0, 0, 0, 1'b0);
        run("R1 R2 R3", 1500, 10, 1'b0, 1'b0);
        do_reset(3, 2, 1, 2, 1'b0);
        run("R6", 3000, 3, 1'b0, 1'b0);
        do_reset(1, 0, 0, 0, 1'b1);
        run("R7", 3000, 30, 1'b0, 1'b0);
        do_reset(2, 4, 3, 1, 1'b1);
        run("R7", 3000, 20, 1'b0, 1'b0);
        do_reset(1, 1, 2, 1, 1'b0);
        run("R9", 3000, 5, 1'b0, 1'b1);
        do_reset(2, 1, 1, 1, 1'b0);
        run("R8", 4000, 4, 1'b1, 1'b0);
        do_reset(0, 0, 1, 0, 1'b1);
        run("R8", 3000, 15, 1'b1, 1'b1);
        do_reset(4, 3, 2, 2, 1'b0);
        run("R10", 3000, 8, 1'b0, 1'b0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule